// File: doc/BRIEF.md
# DRAM Bank Command Timing Tracker

This block watches the command stream aimed at one DRAM bank and decides, cycle by cycle, whether the command offered on its input may be issued now. It keeps one countdown for every pairing of a gated command with an earlier event that restricts it. The gated commands are activate, read, write and precharge, together with the internal start and end of a data burst. When a command is accepted, the timers that the command starts are loaded with the matching DRAM timing value. A command is allowed only when none of the timers that gate it still holds it back.

A scheduler offers one command per cycle and reads `legal_o` in the same cycle. A legal command is taken at the next rising edge. An illegal command is dropped and flagged on `violation_o` during the following cycle. The start and end of data bursts are derived inside the block from the read and write latencies and the burst length. Write recovery and write-to-read turnaround are counted from the end of the write burst.

Top module: `bank_timing_tracker`

## Requirements
- R1: After reset, `last_cmd_o` is 4 (the precharge code), `row_open_o`, `violation_o` and `bus_active_o` are 0, and every timer is clear. Activate and precharge are therefore legal at once, while read and write are not.
- R2: `cmd_i` uses these codes: 0 none, 1 activate, 2 read, 3 write, 4 precharge. Codes 5 to 7 are treated as none. `legal_o` is high only while `cmd_i` carries one of codes 1 to 4 and that command may issue in this cycle. Such a command is taken at that rising edge.
- R3: Suppose an event at edge n loads a timer with value T. The command that timer gates becomes legal no earlier than edge n+max(T,1). Every timer counts down by one per cycle and stops at zero.
- R4: An activate must wait tRC after the previous activate and tRP after a precharge.
- R5: Read and write are legal only while the row is open, meaning the last accepted command was not a precharge. They must also wait tRCD after an activate.
- R6: After a read, a further read waits tCCD, a write waits tRTW and a precharge waits tRTP.
- R7: After an activate, a precharge waits tRAS.
- R8: After a write, a read waits tWR2RD and a further write waits tCCD.
- R9: A burst starts at the edge tRL after a read, or at the edge tWL after a write. `bus_active_o` rises after that edge and falls after the release edge, which comes tBURST later. If a new burst starts at the release edge, `bus_active_o` stays high.
- R10: When a write burst is released, a precharge waits tWR and a read waits tWTR, both counted from the release edge. Releasing a read burst gates nothing.
- R11: An illegal command drives `violation_o` high during exactly the following cycle. It leaves `last_cmd_o`, the row state and every timer unchanged.
- R12: The none code never raises `violation_o` and changes no state.
- R13: Each accepted command is shown on `last_cmd_o` from the next cycle on. An accepted precharge closes the row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 3 | Command offered this cycle |
| legal_o | output | 1 | The offered command may issue now |
| violation_o | output | 1 | The command offered in the previous cycle was illegal |
| row_open_o | output | 1 | A row is open in the bank |
| last_cmd_o | output | 3 | Code of the last accepted command |
| bus_active_o | output | 1 | A data burst of this bank occupies the bus |

## Verification
The timing is first tried with accesses to a closed row, which separates the row-open condition from the timer checks. Back-to-back reads then show that a timer is reloaded at the same edge a burst starts, and that a new burst starting at the release edge keeps `bus_active_o` high. A read followed by a write, and a write followed by a read, tell apart the turnaround counted from the command from the turnaround counted from the burst release. In the write-then-read case the release-based limit is the one that binds. Repeated activates after a precharge, a precharge held back by tRAS, reserved codes, and a reset applied while timers run show which timer blocks each attempt and that rejected or empty cycles leave the state alone.

// File: rtl/bank_timing_pkg.sv
`timescale 1ns/1ps
// Shared codes and indices for the bank timing tracker.
// Event indices 0..3 match the command request bits; 4 and 5 are the
// internal burst-start and write-burst-release events.
package bank_timing_pkg;
    localparam logic [2:0] CODE_NONE = 3'd0;
    localparam logic [2:0] CODE_ACT  = 3'd1;
    localparam logic [2:0] CODE_RD   = 3'd2;
    localparam logic [2:0] CODE_WR   = 3'd3;
    localparam logic [2:0] CODE_PRE  = 3'd4;

    localparam int EV_ACT  = 0;
    localparam int EV_RD   = 1;
    localparam int EV_WR   = 2;
    localparam int EV_PRE  = 3;
    localparam int EV_USE  = 4;
    localparam int EV_RLS  = 5;

    localparam int NUM_CMD = 4;
    localparam int NUM_EV  = 6;
endpackage

// File: rtl/btt_cmd_decode.sv
`timescale 1ns/1ps
// Turns the 3-bit command code into a one-hot request vector.
// Assumes: reserved codes 5..7 behave exactly like the none code.
module btt_cmd_decode
    import bank_timing_pkg::*;
(
    input  logic [2:0]         cmd_i,
    output logic [NUM_CMD-1:0] req_o,
    output logic               is_cmd_o
);
    // One request bit per real command.
    always_comb begin
        req_o = '0;
        case (cmd_i)
            CODE_ACT: req_o[EV_ACT] = 1'b1;
            CODE_RD:  req_o[EV_RD]  = 1'b1;
            CODE_WR:  req_o[EV_WR]  = 1'b1;
            CODE_PRE: req_o[EV_PRE] = 1'b1;
            default:  req_o = '0;
        endcase
    end

    assign is_cmd_o = |req_o;
endmodule

// File: rtl/btt_countdown.sv
`timescale 1ns/1ps
// One lower-bound timer: loads a fixed value on its source event and
// otherwise counts down by one per cycle, holding at zero.
// Assumes: LOAD fits in W bits.
module btt_countdown #(
    parameter int W    = 7,
    parameter int LOAD = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] LOAD_V = W'(LOAD);

    // Load has priority over the saturating decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (load_i)
            cnt_o <= LOAD_V;
        else if (cnt_o != '0)
            cnt_o <= cnt_o - W'(1);
    end
endmodule

// File: rtl/btt_bus_tracker.sv
`timescale 1ns/1ps
// Derives the data-burst start and release events from the bus-use
// timers (started by RD/WR) and the release timer (started by the burst
// start), and holds the bus-occupied flag and the burst direction.
// Assumes: a command does not restart its own bus-use timer while that
// timer is still above one, so at most one burst per kind is pending.
module btt_bus_tracker #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] use_rd_i,
    input  logic [W-1:0] use_wr_i,
    input  logic [W-1:0] rls_i,
    output logic         use_fire_o,
    output logic         rls_wr_fire_o,
    output logic         bus_active_o
);
    logic use_is_wr;
    logic rls_fire;
    logic burst_wr_q;

    // A timer standing at one runs out on this edge.
    assign use_is_wr     = (use_wr_i == W'(1));
    assign use_fire_o    = (use_rd_i == W'(1)) | use_is_wr;
    assign rls_fire      = (rls_i == W'(1));
    assign rls_wr_fire_o = rls_fire & burst_wr_q;

    // Bus flag: a new burst start wins over a release on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_active_o <= 1'b0;
        else if (use_fire_o)
            bus_active_o <= 1'b1;
        else if (rls_fire)
            bus_active_o <= 1'b0;
    end

    // Remember whether the running burst belongs to a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            burst_wr_q <= 1'b0;
        else if (use_fire_o)
            burst_wr_q <= use_is_wr;
    end
endmodule

// File: rtl/bank_timing_tracker.sv
`timescale 1ns/1ps
// Per-bank command legality tracker. A matrix of countdowns, one per
// (gated target, source event) pair that the DRAM timing rules define,
// is built by generate; the other pairs are tied to zero. A command is
// legal when every timer of its target is at most one, i.e. runs out on
// this edge, and for RD/WR only while a row is open.
// Assumes: all timing parameters fit in TMR_W bits; bus latencies >= 1.
module bank_timing_tracker #(
    parameter int TMR_W   = 7,
    parameter int T_RCD   = 14,
    parameter int T_RP    = 14,
    parameter int T_RC    = 48,
    parameter int T_RAS   = 34,
    parameter int T_WL    = 8,
    parameter int T_RL    = 11,
    parameter int T_RTP   = 6,
    parameter int T_WR    = 12,
    parameter int T_RTW   = 9,
    parameter int T_WR2RD = 16,
    parameter int T_WTR   = 6,
    parameter int T_BURST = 4,
    parameter int T_CCD   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cmd_i,
    output logic       legal_o,
    output logic       violation_o,
    output logic       row_open_o,
    output logic [2:0] last_cmd_o,
    output logic       bus_active_o
);
    import bank_timing_pkg::*;

    localparam int W = TMR_W;

    // Load value of the timer (target t, source s); -1 marks no timer.
    function automatic int load_value(input int t, input int s);
        int v;
        v = -1;
        if (t == EV_ACT && s == EV_ACT) v = T_RC;
        if (t == EV_RD  && s == EV_ACT) v = T_RCD;
        if (t == EV_WR  && s == EV_ACT) v = T_RCD;
        if (t == EV_PRE && s == EV_ACT) v = T_RAS;
        if (t == EV_RD  && s == EV_RD)  v = T_CCD;
        if (t == EV_WR  && s == EV_RD)  v = T_RTW;
        if (t == EV_USE && s == EV_RD)  v = T_RL;
        if (t == EV_PRE && s == EV_RD)  v = T_RTP;
        if (t == EV_RD  && s == EV_WR)  v = T_WR2RD;
        if (t == EV_WR  && s == EV_WR)  v = T_CCD;
        if (t == EV_USE && s == EV_WR)  v = T_WL;
        if (t == EV_ACT && s == EV_PRE) v = T_RP;
        if (t == EV_RLS && s == EV_USE) v = T_BURST;
        if (t == EV_PRE && s == EV_RLS) v = T_WR;
        if (t == EV_RD  && s == EV_RLS) v = T_WTR;
        return v;
    endfunction

    logic [NUM_CMD-1:0] req;
    logic               is_cmd;
    logic [NUM_CMD-1:0] clear;
    logic [NUM_CMD-1:0] allow;
    logic [NUM_CMD-1:0] accept;
    logic [NUM_EV-1:0]  src_ev;
    logic [W-1:0]       tmr [NUM_EV][NUM_EV];
    logic               use_fire;
    logic               rls_wr_fire;
    logic [2:0]         last_q;

    btt_cmd_decode u_dec (
        .cmd_i    (cmd_i),
        .req_o    (req),
        .is_cmd_o (is_cmd)
    );

    // Timer matrix: a countdown where a rule exists, a constant zero elsewhere.
    for (genvar t = 0; t < NUM_EV; t++) begin : g_tgt
        for (genvar s = 0; s < NUM_EV; s++) begin : g_src
            localparam int LV = load_value(t, s);
            if (LV >= 0) begin : g_live
                btt_countdown #(.W(W), .LOAD(LV)) u_cnt (
                    .clk    (clk),
                    .rst_n  (rst_n),
                    .load_i (src_ev[s]),
                    .cnt_o  (tmr[t][s])
                );
            end else begin : g_idle
                assign tmr[t][s] = '0;
            end
        end
    end

    // Per-command gate: every timer of the target runs out by this edge.
    for (genvar t = 0; t < NUM_CMD; t++) begin : g_gate
        logic clr;
        always_comb begin
            clr = 1'b1;
            for (int s = 0; s < NUM_EV; s++)
                if (tmr[t][s] > W'(1))
                    clr = 1'b0;
        end
        assign clear[t] = clr;
    end

    assign row_open_o = (last_q != CODE_PRE);

    // Row-state condition on top of the timer gates.
    always_comb begin
        allow         = clear;
        allow[EV_RD]  = clear[EV_RD] & row_open_o;
        allow[EV_WR]  = clear[EV_WR] & row_open_o;
    end

    assign accept  = req & allow;
    assign legal_o = |accept;
    assign src_ev  = {rls_wr_fire, use_fire, accept};

    btt_bus_tracker #(.W(W)) u_bus (
        .clk           (clk),
        .rst_n         (rst_n),
        .use_rd_i      (tmr[EV_USE][EV_RD]),
        .use_wr_i      (tmr[EV_USE][EV_WR]),
        .rls_i         (tmr[EV_RLS][EV_USE]),
        .use_fire_o    (use_fire),
        .rls_wr_fire_o (rls_wr_fire),
        .bus_active_o  (bus_active_o)
    );

    // Record the last accepted command; a closed bank reads as precharge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= CODE_PRE;
        else if (accept[EV_ACT])
            last_q <= CODE_ACT;
        else if (accept[EV_RD])
            last_q <= CODE_RD;
        else if (accept[EV_WR])
            last_q <= CODE_WR;
        else if (accept[EV_PRE])
            last_q <= CODE_PRE;
    end

    // Flag a rejected real command for the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            violation_o <= 1'b0;
        else
            violation_o <= is_cmd & ~legal_o;
    end

    assign last_cmd_o = last_q;
endmodule

// File: rtl/bank_timing_tracker_chk.sv
`timescale 1ns/1ps
// Port-level properties of the bank timing tracker, bound to every instance.
module bank_timing_tracker_chk #(
    parameter int P_RC = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cmd_i,
    input logic       legal_o,
    input logic       violation_o,
    input logic       row_open_o,
    input logic [2:0] last_cmd_o
);
    logic real_cmd;
    assign real_cmd = (cmd_i >= 3'd1) && (cmd_i <= 3'd4);

    // R2
    legal_real_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        legal_o |-> real_cmd);

    // R5
    rdwr_open_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_i == 3'd2 || cmd_i == 3'd3) && legal_o) |-> row_open_o);

    // R11
    viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        violation_o |-> $past(real_cmd && !legal_o));

    // R11
    reject_keeps_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(real_cmd && !legal_o)) |-> $stable(last_cmd_o));

    // R13
    accept_recorded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (real_cmd && legal_o) |=> (last_cmd_o == $past(cmd_i)));

    // R4
    act_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (P_RC > 1 && cmd_i == 3'd1 && legal_o) |=> !(cmd_i == 3'd1 && legal_o));
endmodule

bind bank_timing_tracker bank_timing_tracker_chk #(.P_RC(T_RC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd_i),
    .legal_o     (legal_o),
    .violation_o (violation_o),
    .row_open_o  (row_open_o),
    .last_cmd_o  (last_cmd_o)
);

// File: tb/bank_timing_tracker_tb_top.sv
`timescale 1ns/1ps
// Vector walk plus directed checks for the bank timing tracker.
// Timings: RCD3 RP4 RC10 RAS7 WL2 RL2 RTP2 WR3 RTW4 WR2RD5 WTR2 BURST2 CCD2.
module bank_timing_tracker_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd_i = 3'd0;
    logic       legal_o, violation_o, row_open_o, bus_active_o;
    logic [2:0] last_cmd_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    bank_timing_tracker #(
        .TMR_W(7), .T_RCD(3), .T_RP(4), .T_RC(10), .T_RAS(7), .T_WL(2),
        .T_RL(2), .T_RTP(2), .T_WR(3), .T_RTW(4), .T_WR2RD(5), .T_WTR(2),
        .T_BURST(2), .T_CCD(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .legal_o(legal_o),
        .violation_o(violation_o), .row_open_o(row_open_o),
        .last_cmd_o(last_cmd_o), .bus_active_o(bus_active_o)
    );

    // {cmd[2:0], expected legal_o, expected bus_active_o}, one per cycle
    localparam int NV = 31;
    localparam logic [4:0] VECS [NV] = '{
        {3'd2,1'b0,1'b0}, {3'd0,1'b0,1'b0}, {3'd1,1'b1,1'b0}, {3'd2,1'b0,1'b0},
        {3'd0,1'b0,1'b0}, {3'd2,1'b1,1'b0}, {3'd2,1'b0,1'b0}, {3'd2,1'b1,1'b0},
        {3'd3,1'b0,1'b1}, {3'd0,1'b0,1'b1}, {3'd0,1'b0,1'b1}, {3'd0,1'b0,1'b1},
        {3'd4,1'b1,1'b0}, {3'd1,1'b0,1'b0}, {3'd1,1'b0,1'b0}, {3'd1,1'b0,1'b0},
        {3'd1,1'b1,1'b0}, {3'd3,1'b0,1'b0}, {3'd0,1'b0,1'b0}, {3'd3,1'b1,1'b0},
        {3'd2,1'b0,1'b0}, {3'd0,1'b0,1'b0}, {3'd0,1'b0,1'b1}, {3'd2,1'b0,1'b1},
        {3'd2,1'b0,1'b0}, {3'd4,1'b0,1'b0}, {3'd4,1'b1,1'b0}, {3'd3,1'b0,1'b0},
        {3'd0,1'b0,1'b0}, {3'd5,1'b0,1'b0}, {3'd0,1'b0,1'b0}
    };

    // Requirement exercised by the legality check of each vector
    function automatic string vec_tag(input int k);
        case (k)
            0, 3, 17, 27:     return "R5";
            1, 28, 30:        return "R12";
            2, 13, 14, 15, 16: return "R4";
            4, 5, 18, 19:     return "R3";
            6, 7, 8:          return "R6";
            9, 10, 11, 21, 22: return "R9";
            12:               return "R13";
            20, 23:           return "R8";
            24, 25, 26:       return "R10";
            29:               return "R2";
            default:          return "R3";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] c);
        @(negedge clk);
        cmd_i = c;
        #0.5;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0] vc;
        bit prev_bad;
        prev_bad = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.3;
        // R1: reset state and legality right after reset
        chk("R1", "last_cmd_o", last_cmd_o, 4);
        chk("R1", "row_open_o", row_open_o, 0);
        chk("R1", "violation_o", violation_o, 0);
        chk("R1", "bus_active_o", bus_active_o, 0);
        cmd_i = 3'd1; #0.3; chk("R1", "legal_o ACT", legal_o, 1);
        cmd_i = 3'd4; #0.3; chk("R1", "legal_o PRE", legal_o, 1);
        cmd_i = 3'd3; #0.3; chk("R1", "legal_o WR", legal_o, 0);
        cmd_i = 3'd0;

        for (int k = 0; k < NV; k++) begin
            vc = VECS[k][4:2];
            drive(vc);
            chk(vec_tag(k), "legal_o", legal_o, VECS[k][1]);
            chk("R11", "violation_o", violation_o, prev_bad);
            chk("R9", "bus_active_o", bus_active_o, VECS[k][0]);
            prev_bad = (vc >= 3'd1) && (vc <= 3'd4) && !VECS[k][1];
        end

        // R7: precharge held back by tRAS after an activate
        drive(3'd1); chk("R4", "legal_o ACT", legal_o, 1);
        drive(3'd0);
        chk("R13", "last_cmd_o", last_cmd_o, 1);
        chk("R5", "row_open_o", row_open_o, 1);
        drive(3'd0); drive(3'd0); drive(3'd0); drive(3'd0);
        chk("R12", "last_cmd_o after none", last_cmd_o, 1);
        drive(3'd4); chk("R7", "legal_o PRE early", legal_o, 0);
        drive(3'd4); chk("R7", "legal_o PRE at tRAS", legal_o, 1);
        chk("R11", "violation_o", violation_o, 1);
        chk("R11", "last_cmd_o after reject", last_cmd_o, 1);
        drive(3'd1); chk("R4", "legal_o ACT in tRP", legal_o, 0);
        chk("R13", "last_cmd_o", last_cmd_o, 4);
        chk("R13", "row_open_o", row_open_o, 0);

        // R1: reset while timers are running clears them
        @(negedge clk);
        cmd_i = 3'd0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #0.3;
        chk("R1", "violation_o after reset", violation_o, 0);
        chk("R1", "last_cmd_o after reset", last_cmd_o, 4);
        cmd_i = 3'd1; #0.3; chk("R1", "legal_o ACT after reset", legal_o, 1);
        cmd_i = 3'd0;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule